// File: doc/BRIEF.md
# Streaming Cross-Stencil Engine

This block applies a 13-point cross-shaped finite-difference stencil to a 2D array. The array arrives as a raster stream in row-major order, one element per clock, qualified by a valid flag. For every centre element the stencil takes the centre, the three nearest neighbours on each side within the same row, and the three nearest neighbours above and below in the same column. It multiplies each of these by a fixed signed coefficient and adds the products.

The elements above and below are a whole row length apart in the stream. Six on-chip line delays therefore keep the most recent six rows, so the block never fetches an element twice. The results leave on a valid-qualified output stream at a fixed distance behind the input. If a centre lies close enough to a frame edge that the stencil would reach outside the frame, its result is marked invalid.

Frames follow one another with no gap, and the block keeps track of frame position by itself. Halo data, blocking and frame set-up belong to the surrounding logic. When the input valid flag drops, the whole pipeline holds its state.

Top module: `stencil_engine`

## Requirements
- R1: Each accepted input (inValid high at a rising edge) advances the pipeline by one step. The result whose centre is stream element m is registered at the edge that accepts element m + 3*ROW_LEN + 4, and it is visible on outData/outValid from that edge onward.
- R2: The result is the sum of 13 signed tap-times-coefficient products, with the coefficient array indexed as follows: 0 = centre; 1..3 = the element d = 1..3 positions earlier in the same row; 4..6 = the element d positions later in the same row; 7..9 = the element d rows above; 10..12 = the element d rows below.
- R3: The sum is formed at full precision, shifted right arithmetically by COEF_FRAC bits, and truncated to its low OUT_W bits in two's complement, so results that do not fit wrap around.
- R4: outValid stays low until at least 3*ROW_LEN+4 inputs have been accepted after reset. The first high outValid belongs to centre row 3, column 3 of the first frame.
- R5: A centre whose column is below 3 or above ROW_LEN-4 never produces a high outValid.
- R6: A centre whose row is below 3 or above NUM_ROWS-4 never produces a high outValid. Each frame therefore yields exactly (ROW_LEN-6)*(NUM_ROWS-6) valid results.
- R7: A cycle without inValid is a stall. In the cycle after a stall, outValid is low and outData holds its value. A stall has no effect on alignment or on any later result.
- R8: Frames of ROW_LEN*NUM_ROWS elements may follow one another with no gap. Column and row positions wrap at the end of a frame, and the next frame's results are correct.
- R9: While rstN is low, outValid and outData are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input element qualifier; low stalls the pipeline |
| inData | input | DATA_W | Signed input element, row-major order |
| outValid | output | 1 | High for one cycle per interior result |
| outData | output | OUT_W | Truncated weighted sum |

## Verification
A wrong line-delay address or a tap shift register that is off by one stage mixes the wrong rows or columns into the sum. This corrupts the very first interior result, 3*ROW_LEN+4 accepted inputs after it entered, so a scoreboard mismatch shows up once the first frame's first interior result comes out. A fault in the warm-up or position counters moves outValid to the wrong cycles. That appears as a first result at the wrong accepted-input count, as results with no matching expectation, or as a wrong per-frame result count. A stall that fails to freeze some stage shows as wrong data after the first stall in the bench's randomly stalled frame.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

  localparam int TAPS  = 13;
  localparam int REACH = 3;
  localparam int LINES = 2 * REACH;

  typedef struct packed {
    logic advance;
    logic emit;
  } stencil_strobe_t;

endpackage

// File: rtl/stencil_linebuf.sv
module stencil_linebuf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 511,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              advance,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  // read-before-write on one shared address; the output register adds one slot
  always_ff @(posedge clk) begin
    if (advance) begin
      rdData    <= mem[addr];
      mem[addr] <= wrData;
    end
  end

endmodule

// File: rtl/stencil_ctrl.sv
module stencil_ctrl
  import stencil_pkg::*;
#(
  parameter int ROW_LEN  = 512,
  parameter int NUM_ROWS = 512,
  localparam int DEPTH   = ROW_LEN - 1,
  localparam int AW      = $clog2(DEPTH),
  localparam int WARM    = REACH * ROW_LEN + REACH + 1,
  localparam int WW      = $clog2(WARM + 1),
  localparam int CW      = $clog2(ROW_LEN),
  localparam int RW      = $clog2(NUM_ROWS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output stencil_strobe_t strb,
  output logic [AW-1:0]   bufAddr
);

  logic [WW-1:0] warmCnt;
  logic          warmDone;
  logic [CW-1:0] colC;
  logic [RW-1:0] rowC;
  logic          interior;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr <= '0;
    end else if (inValid) begin
      bufAddr <= (bufAddr == AW'(DEPTH - 1)) ? '0 : bufAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt  <= '0;
      warmDone <= 1'b0;
      colC     <= '0;
      rowC     <= '0;
    end else if (inValid) begin
      if (!warmDone) begin
        warmCnt <= warmCnt + 1'b1;
        if (warmCnt == WW'(WARM - 1)) warmDone <= 1'b1;
      end else if (colC == CW'(ROW_LEN - 1)) begin
        colC <= '0;
        rowC <= (rowC == RW'(NUM_ROWS - 1)) ? '0 : rowC + 1'b1;
      end else begin
        colC <= colC + 1'b1;
      end
    end
  end

  always_comb begin
    interior = (colC >= CW'(REACH)) && (colC <= CW'(ROW_LEN - 1 - REACH)) &&
               (rowC >= RW'(REACH)) && (rowC <= RW'(NUM_ROWS - 1 - REACH));
    strb.advance = inValid;
    strb.emit    = warmDone && interior;
  end

  // R1: the shared delay address stays inside the line memories
  a_r1_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    bufAddr <= AW'(DEPTH - 1));

  // R5: the centre column counter never leaves the row
  a_r5_col_range: assert property (@(posedge clk) disable iff (!rstN)
    colC <= CW'(ROW_LEN - 1));

  // R8: the last element of a frame returns position to the frame origin
  a_r8_frame_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && warmDone && colC == CW'(ROW_LEN - 1) && rowC == RW'(NUM_ROWS - 1))
    |=> (colC == '0 && rowC == '0));

endmodule

// File: rtl/stencil_datapath.sv
module stencil_datapath
  import stencil_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 8,
  parameter int OUT_W     = 24,
  parameter int COEF_FRAC = 2,
  parameter int ROW_LEN   = 512,
  parameter int COEF [TAPS] = '{default: 0},
  localparam int DEPTH    = ROW_LEN - 1,
  localparam int AW       = $clog2(DEPTH),
  localparam int ACC_RAW  = DATA_W + COEF_W + 4,
  localparam int ACC_W    = (ACC_RAW > OUT_W + COEF_FRAC) ? ACC_RAW : OUT_W + COEF_FRAC
) (
  input  logic               clk,
  input  logic               rstN,
  input  stencil_strobe_t    strb,
  input  logic [AW-1:0]      bufAddr,
  input  logic [DATA_W-1:0]  inData,
  output logic               outValid,
  output logic [OUT_W-1:0]   outData
);

  logic [DATA_W-1:0]                   inReg;
  logic [LINES:0][DATA_W-1:0]          lineStream;
  logic [LINES:0][DATA_W-1:0]          colTap;
  logic [REACH:1][DATA_W-1:0]          westTap;
  logic [REACH:1][DATA_W-1:0]          eastTap;
  logic signed [DATA_W-1:0]            tap [TAPS];
  logic signed [ACC_W-1:0]             acc;
  logic signed [ACC_W-1:0]             scaled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             inReg <= '0;
    else if (strb.advance) inReg <= inData;
  end

  assign lineStream[0] = inReg;

  // chain of six one-row delays; lineStream[k] is k rows behind the input
  for (genvar k = 1; k <= LINES; k++) begin : gLine
    stencil_linebuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uBuf (
      .clk    (clk),
      .advance(strb.advance),
      .addr   (bufAddr),
      .wrData (lineStream[k-1]),
      .rdData (lineStream[k])
    );
  end

  // per-row element delays; the centre row keeps 2*REACH stages for the row taps
  for (genvar k = 0; k <= LINES; k++) begin : gRow
    localparam int STAGES = (k == REACH) ? 2 * REACH : REACH;
    logic [DATA_W-1:0] stg [1:STAGES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int j = 1; j <= STAGES; j++) stg[j] <= '0;
      end else if (strb.advance) begin
        stg[1] <= lineStream[k];
        for (int j = 2; j <= STAGES; j++) stg[j] <= stg[j-1];
      end
    end

    assign colTap[k] = stg[REACH];

    if (k == REACH) begin : gCentre
      for (genvar d = 1; d <= REACH; d++) begin : gSide
        assign westTap[d] = stg[REACH + d];
        if (d == REACH) begin : gNewest
          assign eastTap[d] = lineStream[k];
        end else begin : gMid
          assign eastTap[d] = stg[REACH - d];
        end
      end
    end
  end

  // coefficient order: centre, west 1..3, east 1..3, north 1..3, south 1..3
  assign tap[0] = colTap[REACH];
  for (genvar d = 1; d <= REACH; d++) begin : gTapMap
    assign tap[d]             = westTap[d];
    assign tap[REACH + d]     = eastTap[d];
    assign tap[2 * REACH + d] = colTap[REACH + d];
    assign tap[3 * REACH + d] = colTap[REACH - d];
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + ACC_W'(tap[i]) * ACC_W'(COEF[i]);
    end
    scaled = acc >>> COEF_FRAC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (strb.advance) begin
      outValid <= strb.emit;
      outData  <= scaled[OUT_W-1:0];
    end else begin
      outValid <= 1'b0;
    end
  end

  // R7: a stall freezes the centre tap
  a_r7_taps_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(colTap[REACH]));

endmodule

// File: rtl/stencil_engine.sv
module stencil_engine
  import stencil_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 8,
  parameter int OUT_W     = 24,
  parameter int COEF_FRAC = 2,
  parameter int ROW_LEN   = 512,
  parameter int NUM_ROWS  = 512,
  parameter int COEF [TAPS] = '{-24, 5, -3, 1, 6, -2, 2, 7, -4, 1, 8, -1, 3},
  localparam int AW       = $clog2(ROW_LEN - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData
);

  stencil_strobe_t strb;
  logic [AW-1:0]   bufAddr;

  stencil_ctrl #(.ROW_LEN(ROW_LEN), .NUM_ROWS(NUM_ROWS)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strb   (strb),
    .bufAddr(bufAddr)
  );

  stencil_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
    .COEF_FRAC(COEF_FRAC), .ROW_LEN(ROW_LEN), .COEF(COEF)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bufAddr (bufAddr),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );

  // R1: a result only follows an accepted input
  a_r1_valid_after_input: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R7: after a stall cycle the output is idle and holds its data
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outData)));

endmodule

// File: tb/stencil_engine_test.sv
module stencil_engine_test;

  localparam int DW   = 12;
  localparam int CWID = 8;
  localparam int OW   = 16;
  localparam int FR   = 2;
  localparam int L    = 12;
  localparam int R    = 10;
  localparam int FRAME = L * R;
  localparam int WARM = 3 * L + 4;
  localparam int PER_FRAME = (L - 6) * (R - 6);
  localparam int K [13] = '{-24, 5, -3, 1, 6, -2, 2, 7, -4, 1, 8, -1, 3};

  typedef struct {
    logic [OW-1:0] val;
    int            n;
    int            fr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          outValid;
  logic [OW-1:0] outData;

  exp_t    q[$];
  longint  hist[$];
  int      total = 0;
  int      accepted = 0;
  int      checks = 0;
  int      fails = 0;
  int      frameCount [4] = '{0, 0, 0, 0};
  logic    lastEdgeValid = 1'b0;
  logic [OW-1:0] prevOut = '0;
  bit      running = 1'b0;
  bit      seenFirst = 1'b0;
  bit      done = 1'b0;

  stencil_engine #(
    .DATA_W(DW), .COEF_W(CWID), .OUT_W(OW), .COEF_FRAC(FR),
    .ROW_LEN(L), .NUM_ROWS(R), .COEF(K)
  ) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    lastEdgeValid <= inValid;
    if (rstN && inValid) accepted <= accepted + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [DW-1:0] v, input string tag);
    int m;
    longint s;
    logic [OW-1:0] e;
    exp_t it;
    inData  = v;
    inValid = 1'b1;
    hist.push_back(longint'($signed(v)));
    m = total - WARM;
    if (m >= 0) begin
      int p, rr, cc;
      p  = m % FRAME;
      rr = p / L;
      cc = p % L;
      if (rr >= 3 && rr <= R - 4 && cc >= 3 && cc <= L - 4) begin
        s = K[0] * hist[m];
        for (int d = 1; d <= 3; d++) begin
          s += K[d]     * hist[m - d];
          s += K[3 + d] * hist[m + d];
          s += K[6 + d] * hist[m - d * L];
          s += K[9 + d] * hist[m + d * L];
        end
        s = s >>> FR;
        e = s[OW-1:0];
        it.val = e; it.n = total; it.fr = m / FRAME; it.tag = tag;
        q.push_back(it);
      end
    end
    total++;
    @(negedge clk);
  endtask

  task automatic stall(input int cycles);
    inValid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (!lastEdgeValid) begin
        check(!outValid, "R7 idle after stall", outValid, 0);
        check(outData == prevOut, "R7 data held", outData, prevOut);
      end
      if (outValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R5/R6 unexpected result", outData, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(outData == e.val, e.tag, outData, e.val);
          check(accepted == e.n + 1, "R1 latency", accepted, e.n + 1);
          if (e.fr < 4) frameCount[e.fr]++;
          if (!seenFirst) begin
            seenFirst = 1'b1;
            check(accepted == WARM + 3 * L + 3 + 1, "R4 first result", accepted,
                  WARM + 3 * L + 3 + 1);
          end
        end
      end
      prevOut = outData;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R9 reset valid", outValid, 0);
    check(outData == '0, "R9 reset data", outData, 0);
    rstN = 1'b1;
    @(negedge clk);
    prevOut = outData;
    running = 1'b1;
    stall(3);

    // frame 0: ramp, no stalls (R2)
    for (int i = 0; i < FRAME; i++) drive(DW'((i / L) * 37 + (i % L) * 5 - 300), "R2");

    // frame 1: random data with random stalls (R8, R7)
    for (int i = 0; i < FRAME; i++) begin
      drive(DW'($urandom), "R8");
      if ($urandom % 4 == 0) stall(1 + ($urandom % 3));
    end

    // frame 2: extreme checkerboard forcing wrap-around (R3)
    for (int i = 0; i < FRAME; i++)
      drive((((i / L) + (i % L)) % 2 == 0) ? DW'(2047) : DW'(-2048), "R3");

    // flush: one row of the next frame
    for (int i = 0; i < L; i++) drive('0, "R8");
    stall(6);

    check(q.size() == 0, "R6 all results delivered", q.size(), 0);
    check(frameCount[0] == PER_FRAME, "R5 frame 0 count", frameCount[0], PER_FRAME);
    check(frameCount[1] == PER_FRAME, "R6 frame 1 count", frameCount[1], PER_FRAME);
    check(frameCount[2] == PER_FRAME, "R8 frame 2 count", frameCount[2], PER_FRAME);
    check(seenFirst, "R4 any result", seenFirst, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule